// File: doc/BRIEF.md
# Link Power Monitor and Wake Controller

This block sits between a physical-layer device and the link-layer controller attached to it. It watches the controller's power-status pin and sorts it into three conditions: active, a shallow low-power reset, and a deep low-power disable. A low that is shorter than the first threshold is treated as a glitch and does nothing. A low that lasts past the first threshold stops the control, data and request paths but keeps the interface clock running. A low that lasts past the second, longer threshold also stops the interface clock. When the pin goes high again the interface comes back to normal. A bus reset is requested only if the return comes out of the deep level.

The block also drives a wake output. This output is a square wave that tells a sleeping link-layer controller to power up. It runs when the link counts as inactive and a link-on packet has arrived or an enabled interrupt is pending. It also runs for a limited window after power-up when the node's power class is low enough. It stops once the link is fully active. A bus reset also stops it, unless an enabled interrupt is pending. The link-active flag that goes into the self-identification data is produced here as well.

All timings are parameters counted in system clock cycles. The power-status pin passes through a two-stage synchronizer before any timing is applied.

Top module: `link_pwr_wake`

## Requirements
- R1: While `rst` is high, and after it until the synchronized `lps_in` is seen high, `io_en`, `pclk_en`, `link_active`, `wake_out` and `bus_rst_req` are all 0. Leaving this reset-held disabled condition does not pulse `bus_rst_req`.
- R2: A low on `lps_in` that lasts fewer than RST_CYC synchronized cycles leaves `io_en` at 1 the whole time.
- R3: After `lps_in` has been low for RST_CYC synchronized cycles, `io_en` is 0 and `pclk_en` stays 1. Here `io_en` = 0 means the control and data outputs are forced to 0 and link requests are ignored.
- R4: After `lps_in` has been low for DIS_CYC synchronized cycles (DIS_CYC > RST_CYC), `pclk_en` is also 0.
- R5: When `lps_in` goes high from the shallow level, `io_en` and `pclk_en` return to 1 and `bus_rst_req` stays 0.
- R6: When `lps_in` goes high from the deep level that was entered by timing, `bus_rst_req` is 1 for exactly one cycle, in the same cycle that `io_en` and `pclk_en` return to 1.
- R7: `link_active` is 1 exactly when the interface is active (`io_en` = 1) and `link_ctrl` is 1. It is registered one cycle after `link_ctrl`.
- R8: A `linkon_evt` pulse starts `wake_out` only while the link is inactive. While the link is active the pulse is ignored.
- R9: A pending interrupt (`intr_pending` = 1) starts the wake output only when `wdog_en` = 1 and the link is inactive. If the link is active when the interrupt is pending, the wake starts once the link becomes inactive.
- R10: While a wake is in progress, `wake_out` is a square wave that starts high, with HALF_CYC cycles high and HALF_CYC cycles low.
- R11: One cycle after `link_active` is 1, `wake_out` is 0. Any latched wake request and any power-up window are cleared.
- R12: A `bus_reset` pulse clears a latched wake request, unless `intr_pending` and `wdog_en` are both 1 at that pulse.
- R13: A `pwr_up` pulse with `pwr_class` in 0 to 4 runs the wake output for PU_CYC cycles, or until the link becomes active if that is sooner. With `pwr_class` in 5 to 7 the pulse has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| lps_in | input | 1 | Link power-status pin, asynchronous |
| link_ctrl | input | 1 | Software link-control bit |
| linkon_evt | input | 1 | One-cycle pulse: link-on packet for this node received |
| intr_pending | input | 1 | PHY interrupt condition pending (level) |
| wdog_en | input | 1 | Enables interrupt-driven wake |
| bus_reset | input | 1 | One-cycle pulse: a bus reset is occurring |
| pwr_up | input | 1 | One-cycle pulse: power cycle completed |
| pwr_class | input | 3 | Node power class, 0 to 7 |
| io_en | output | 1 | Control/data drive and link-request acceptance enable |
| pclk_en | output | 1 | Interface clock output enable |
| bus_rst_req | output | 1 | One-cycle bus reset request |
| link_active | output | 1 | Link-active flag for self-identification |
| wake_out | output | 1 | Square-wave wake signal to the link controller |

## Verification
A wrong power level shows up at `io_en` and `pclk_en` in the same cycle that the state register moves. For example, if the block counts the synchronized low cycles one too many or one too few, the edge of `io_en` moves by one cycle. The per-clock reference comparison catches that at once. A lost or spurious deep-level flag shows as a missing or extra `bus_rst_req` pulse on the first cycle that the pin goes high. A wake request that should have been cleared, or a square-wave phase that has drifted, shows on `wake_out` within one half-period.

// File: rtl/lpw_pkg.sv
package lpw_pkg;
  typedef enum logic [1:0] {
    LP_ACTIVE   = 2'd0,
    LP_RESET    = 2'd1,
    LP_DISABLED = 2'd2
  } lp_state_t;
endpackage

// File: rtl/lpw_sync.sv
module lpw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= 1'b0;
    else     chain[0] <= d_in;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b0;
        else     chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/lpw_power_fsm.sv
module lpw_power_fsm
  import lpw_pkg::*;
#(
  parameter int RST_CYC = 16,
  parameter int DIS_CYC = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic lps_s,
  input  logic link_ctrl,
  output logic io_en,
  output logic pclk_en,
  output logic bus_rst_req,
  output logic link_active
);
  localparam int CW = $clog2(DIS_CYC + 1);
  localparam logic [CW-1:0] RST_W = CW'(RST_CYC);
  localparam logic [CW-1:0] DIS_W = CW'(DIS_CYC);

  lp_state_t       st, st_nxt;
  logic [CW-1:0]   lo_cnt, lo_next;
  logic            hw_hold;
  logic            brq_nxt;

  always_comb begin
    lo_next = lo_cnt;
    if (lps_s)                lo_next = '0;
    else if (lo_cnt != DIS_W) lo_next = lo_cnt + 1'b1;

    st_nxt  = st;
    brq_nxt = 1'b0;
    case (st)
      LP_ACTIVE:   if (!lps_s && lo_next >= RST_W) st_nxt = LP_RESET;
      LP_RESET: begin
        if (lps_s)                  st_nxt = LP_ACTIVE;
        else if (lo_next >= DIS_W)  st_nxt = LP_DISABLED;
      end
      LP_DISABLED: begin
        if (lps_s) begin
          st_nxt  = LP_ACTIVE;
          brq_nxt = !hw_hold;
        end
      end
      default:     st_nxt = LP_DISABLED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= LP_DISABLED;
      lo_cnt      <= '0;
      hw_hold     <= 1'b1;
      io_en       <= 1'b0;
      pclk_en     <= 1'b0;
      bus_rst_req <= 1'b0;
      link_active <= 1'b0;
    end else begin
      st          <= st_nxt;
      lo_cnt      <= lo_next;
      if (st == LP_RESET && st_nxt == LP_DISABLED) hw_hold <= 1'b0;
      io_en       <= (st_nxt == LP_ACTIVE);
      pclk_en     <= (st_nxt != LP_DISABLED);
      bus_rst_req <= brq_nxt;
      link_active <= (st_nxt == LP_ACTIVE) && link_ctrl;
    end
  end

  AST_IO_NEEDS_CLK: assert property (@(posedge clk) disable iff (rst)
    io_en |-> pclk_en); // R3

  AST_CLK_STOP_FROM_SHALLOW: assert property (@(posedge clk) disable iff (rst)
    $fell(pclk_en) |-> $past(!io_en)); // R4

  AST_BRQ_FROM_DEEP: assert property (@(posedge clk) disable iff (rst)
    bus_rst_req |-> ($past(!pclk_en) && pclk_en && io_en)); // R6

  AST_BRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    bus_rst_req |=> !bus_rst_req); // R6

  AST_LA_NEEDS_IO: assert property (@(posedge clk) disable iff (rst)
    link_active |-> io_en); // R7
endmodule

// File: rtl/lpw_wake.sv
module lpw_wake #(
  parameter int HALF_CYC = 4,
  parameter int PU_CYC   = 200
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       link_active,
  input  logic       linkon_evt,
  input  logic       intr_pending,
  input  logic       wdog_en,
  input  logic       bus_reset,
  input  logic       pwr_up,
  input  logic [2:0] pwr_class,
  output logic       wake_out
);
  localparam int PW = $clog2(PU_CYC + 1);
  localparam int HW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [PW-1:0] PU_W   = PW'(PU_CYC);
  localparam logic [HW-1:0] HALF_L = HW'(HALF_CYC - 1);

  logic          wreq;
  logic [PW-1:0] pu_cnt;
  logic [HW-1:0] hc;
  logic          phase;
  logic          irq_ok;
  logic          won;

  assign irq_ok = intr_pending & wdog_en;
  assign won    = wreq | (pu_cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      wreq   <= 1'b0;
      pu_cnt <= '0;
      hc     <= '0;
      phase  <= 1'b1;
    end else begin
      if (link_active)                  wreq <= 1'b0;
      else if (bus_reset)               wreq <= irq_ok;
      else if (linkon_evt || irq_ok)    wreq <= 1'b1;

      if (link_active)                          pu_cnt <= '0;
      else if (pwr_up && pwr_class <= 3'd4)     pu_cnt <= PU_W;
      else if (pu_cnt != '0)                    pu_cnt <= pu_cnt - 1'b1;

      if (!won) begin
        hc    <= '0;
        phase <= 1'b1;
      end else if (hc == HALF_L) begin
        hc    <= '0;
        phase <= ~phase;
      end else begin
        hc    <= hc + 1'b1;
      end
    end
  end

  assign wake_out = won & phase;

  AST_WAKE_OFF_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    link_active |=> !wake_out); // R11

  AST_NO_WAKE_FROM_BLOCKED_IRQ: assert property (@(posedge clk) disable iff (rst)
    (!wake_out && !won && !linkon_evt && !pwr_up && !(intr_pending && wdog_en)) |=> !wake_out); // R9
endmodule

// File: rtl/link_pwr_wake.sv
module link_pwr_wake #(
  parameter int SYNC_STAGES = 2,
  parameter int RST_CYC     = 16,
  parameter int DIS_CYC     = 64,
  parameter int HALF_CYC    = 4,
  parameter int PU_CYC      = 200
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       lps_in,
  input  logic       link_ctrl,
  input  logic       linkon_evt,
  input  logic       intr_pending,
  input  logic       wdog_en,
  input  logic       bus_reset,
  input  logic       pwr_up,
  input  logic [2:0] pwr_class,
  output logic       io_en,
  output logic       pclk_en,
  output logic       bus_rst_req,
  output logic       link_active,
  output logic       wake_out
);
  logic lps_s;

  lpw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  (lps_in),
    .d_out (lps_s)
  );

  lpw_power_fsm #(.RST_CYC(RST_CYC), .DIS_CYC(DIS_CYC)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .lps_s       (lps_s),
    .link_ctrl   (link_ctrl),
    .io_en       (io_en),
    .pclk_en     (pclk_en),
    .bus_rst_req (bus_rst_req),
    .link_active (link_active)
  );

  lpw_wake #(.HALF_CYC(HALF_CYC), .PU_CYC(PU_CYC)) u_wake (
    .clk          (clk),
    .rst          (rst),
    .link_active  (link_active),
    .linkon_evt   (linkon_evt),
    .intr_pending (intr_pending),
    .wdog_en      (wdog_en),
    .bus_reset    (bus_reset),
    .pwr_up       (pwr_up),
    .pwr_class    (pwr_class),
    .wake_out     (wake_out)
  );

  initial begin
    AST_THRESH_ORDER: assert (DIS_CYC > RST_CYC && RST_CYC > 0); // R4
  end
endmodule

// File: tb/tb_link_pwr_wake.sv
`timescale 1ns/1ps
module tb_link_pwr_wake;
  localparam int RST_CYC  = 16;
  localparam int DIS_CYC  = 64;
  localparam int HALF_CYC = 4;
  localparam int PU_CYC   = 200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lps_in = 1'b1, link_ctrl = 1'b1, linkon_evt = 1'b0, intr_pending = 1'b0;
  logic wdog_en = 1'b0, bus_reset = 1'b0, pwr_up = 1'b0;
  logic [2:0] pwr_class = 3'd0;
  logic io_en, pclk_en, bus_rst_req, link_active, wake_out;

  always #2.5 clk = ~clk;

  link_pwr_wake #(.RST_CYC(RST_CYC), .DIS_CYC(DIS_CYC), .HALF_CYC(HALF_CYC), .PU_CYC(PU_CYC)) dut (
    .clk(clk), .rst(rst), .lps_in(lps_in), .link_ctrl(link_ctrl), .linkon_evt(linkon_evt),
    .intr_pending(intr_pending), .wdog_en(wdog_en), .bus_reset(bus_reset), .pwr_up(pwr_up),
    .pwr_class(pwr_class), .io_en(io_en), .pclk_en(pclk_en), .bus_rst_req(bus_rst_req),
    .link_active(link_active), .wake_out(wake_out));

  int checks = 0, failures = 0;
  int brq_cnt = 0, io_low = 0, wk_hi = 0;
  bit finished = 0;

  // reference model state
  int s1 = 0, s2 = 0, run = 0, mst = 2;
  bit mhw = 1, m_brq = 0, m_la = 0, m_wreq = 0;
  int m_pu = 0, m_el = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin : mdl
    int s, nst;
    bit irq, won, m_io, m_clk, m_wake;
    if (rst) begin
      s1 = 0; s2 = 0; run = 0; mst = 2; mhw = 1; m_brq = 0; m_la = 0;
      m_wreq = 0; m_pu = 0; m_el = 0;
    end else begin
      s = s2; s2 = s1; s1 = lps_in;
      if (s != 0) run = 0; else if (run < DIS_CYC) run = run + 1;
      nst = mst; m_brq = 0;
      if (s != 0 && mst != 0) begin
        nst = 0;
        if (mst == 2 && !mhw) m_brq = 1;
      end else if (mst == 0 && run >= RST_CYC) nst = 1;
      else if (mst == 1 && run >= DIS_CYC) begin nst = 2; mhw = 0; end
      irq = intr_pending && wdog_en;
      won = m_wreq || (m_pu > 0);
      m_el = won ? m_el + 1 : 0;
      if (m_la) m_wreq = 0;
      else if (bus_reset) m_wreq = irq;
      else if (linkon_evt || irq) m_wreq = 1;
      if (m_la) m_pu = 0;
      else if (pwr_up && pwr_class <= 3'd4) m_pu = PU_CYC;
      else if (m_pu > 0) m_pu = m_pu - 1;
      mst = nst;
      m_la = (nst == 0) && link_ctrl;
    end
    m_io   = (mst == 0);
    m_clk  = (mst != 2);
    m_wake = (m_wreq || m_pu > 0) && ((m_el / HALF_CYC) % 2 == 0);
    #1;
    if (!finished) begin
      chk("R3 io_en", io_en, m_io);
      chk("R4 pclk_en", pclk_en, m_clk);
      chk("R6 bus_rst_req", bus_rst_req, m_brq);
      chk("R7 link_active", link_active, m_la);
      chk("R10 wake_out", wake_out, m_wake);
    end
    if (bus_rst_req) brq_cnt++;
    if (!io_en) io_low++;
    if (wake_out) wk_hi++;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    int b0, prev, rises;
    cyc(4);
    chk("R1 io_en in reset", io_en, 0);
    chk("R1 pclk_en in reset", pclk_en, 0);
    chk("R1 link_active in reset", link_active, 0);
    chk("R1 wake_out in reset", wake_out, 0);
    chk("R1 bus_rst_req in reset", bus_rst_req, 0);
    rst = 1'b0;
    cyc(6);
    chk("R1 io_en after release", io_en, 1);
    chk("R1 no bus reset leaving reset hold", brq_cnt, 0);
    chk("R7 link_active with ctrl set", link_active, 1);

    io_low = 0;
    lps_in = 1'b0; cyc(RST_CYC - 4);
    lps_in = 1'b1; cyc(6);
    chk("R2 short low ignored", io_low, 0);

    lps_in = 1'b0; cyc(RST_CYC + 6);
    chk("R3 io_en off in shallow", io_en, 0);
    chk("R3 pclk_en kept in shallow", pclk_en, 1);
    chk("R7 link_active off in shallow", link_active, 0);
    b0 = brq_cnt;
    lps_in = 1'b1; cyc(6);
    chk("R5 io_en back", io_en, 1);
    chk("R5 pclk_en back", pclk_en, 1);
    chk("R5 no bus reset from shallow", brq_cnt, b0);

    lps_in = 1'b0; cyc(DIS_CYC + 6);
    chk("R4 pclk_en off in deep", pclk_en, 0);
    chk("R4 io_en off in deep", io_en, 0);
    lps_in = 1'b1; cyc(6);
    chk("R6 one bus reset from deep", brq_cnt, b0 + 1);
    chk("R6 io_en back", io_en, 1);

    link_ctrl = 1'b0; cyc(2);
    chk("R7 link_active follows ctrl low", link_active, 0);
    link_ctrl = 1'b1; cyc(2);
    chk("R7 link_active follows ctrl high", link_active, 1);

    wk_hi = 0;
    pulse(linkon_evt); cyc(20);
    chk("R8 link-on ignored while active", wk_hi, 0);
    link_ctrl = 1'b0; cyc(3);
    pulse(linkon_evt); cyc(10);
    chk("R8 link-on wakes inactive link", (wk_hi > 0) ? 1 : 0, 1);
    prev = wake_out; rises = 0;
    for (int i = 0; i < 8 * HALF_CYC; i++) begin
      cyc(1);
      if (wake_out && !prev) rises++;
      prev = wake_out;
    end
    chk("R10 four periods in window", rises, 4);
    link_ctrl = 1'b1; cyc(3);
    wk_hi = 0; cyc(20);
    chk("R11 wake stops when link active", wk_hi, 0);

    intr_pending = 1'b1; wdog_en = 1'b1; cyc(3);
    wk_hi = 0; cyc(20);
    chk("R9 enabled irq no wake while active", wk_hi, 0);
    link_ctrl = 1'b0; cyc(10);
    chk("R9 enabled irq wakes once inactive", (wk_hi > 0) ? 1 : 0, 1);
    link_ctrl = 1'b1; cyc(3);
    wdog_en = 1'b0; link_ctrl = 1'b0; cyc(3);
    wk_hi = 0; cyc(20);
    chk("R9 irq without enable no wake", wk_hi, 0);

    wdog_en = 1'b1; cyc(5);
    pulse(bus_reset); cyc(3);
    wk_hi = 0; cyc(10);
    chk("R12 bus reset keeps wake with irq", (wk_hi > 0) ? 1 : 0, 1);
    intr_pending = 1'b0; cyc(5);
    pulse(bus_reset); cyc(3);
    wk_hi = 0; cyc(20);
    chk("R12 bus reset clears wake", wk_hi, 0);

    pwr_class = 3'd5; pulse(pwr_up); cyc(3);
    wk_hi = 0; cyc(20);
    chk("R13 class 5 power-up no wake", wk_hi, 0);
    pwr_class = 3'd3; pulse(pwr_up); cyc(3);
    wk_hi = 0; cyc(PU_CYC - 20);
    chk("R13 power-up window wakes", (wk_hi > 0) ? 1 : 0, 1);
    cyc(30);
    wk_hi = 0; cyc(20);
    chk("R13 power-up window expires", wk_hi, 0);
    pwr_class = 3'd0; pulse(pwr_up); cyc(10);
    link_ctrl = 1'b1; cyc(3);
    wk_hi = 0; cyc(20);
    chk("R13 power-up window ends early on active link", wk_hi, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule